// File: doc/BRIEF.md
# Flash Host Write Gate

This block sits between the host-facing control strobes of a NOR-style flash model and the model's command state machine. It samples the active-low chip-enable, output-enable and write-enable strobes on a fast clock. Each strobe passes through a synchronizer and then a minimum-width filter, so short noise pulses never reach the decision logic. The block then decides whether a host bus cycle is a real write. A write is recognised only while chip-enable and write-enable are both low and output-enable is high. The supply must also be reported good, and the gate must be armed.

When a qualified cycle begins, the block captures the address and data buses. When the cycle ends cleanly, because write-enable or chip-enable returns high, it hands both values to the command logic with a single-cycle strobe. The block also produces a one-cycle pulse that sends the command logic back to reading the array. This pulse fires after power-on reset and whenever the supply-good flag drops.

A power-up inhibit stops a cycle that was already held low through reset from being taken as a command. The gate stays disarmed until write-enable or chip-enable has been seen high with the supply good. The reset is synchronous, driven by the power-on input.

Top module: `flash_write_guard`

## Requirements
- R1: While `por` is high no commit strobe is produced. Exactly one `force_read` pulse of one cycle follows the release of `por`.
- R2: A cycle with chip-enable low, output-enable high and write-enable held low for at least GLITCH_MIN sample clocks produces exactly one `wr_stb` after write-enable rises. That strobe carries the address and data present when the cycle started.
- R3: `wr_stb` is never high for two consecutive clocks.
- R4: While output-enable is low, strobing chip-enable and write-enable produces no `wr_stb`.
- R5: A write-enable low pulse shorter than GLITCH_MIN sample clocks produces no `wr_stb`.
- R6: While `vcc_ok` is low, complete write cycles produce no `wr_stb`. A falling `vcc_ok` produces a one-cycle `force_read` pulse.
- R7: If `vcc_ok` falls during a started cycle, the cycle is dropped and no `wr_stb` follows.
- R8: If chip-enable and write-enable are low while `por` is released, the next write-enable rise gives no `wr_stb`. A later full cycle is accepted.
- R9: Changing the address and data buses after a cycle has started does not change the values delivered with `wr_stb`.
- R10: A cycle that ends by chip-enable rising while write-enable is low also commits, with one `wr_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| por | input | 1 | Power-on indication, active high, synchronous reset |
| vcc_ok | input | 1 | Supply above lockout level, from an external comparator |
| ce_n | input | 1 | Host chip-enable, active low |
| oe_n | input | 1 | Host output-enable, active low |
| we_n | input | 1 | Host write-enable, active low |
| addr | input | ADDR_W | Host address bus |
| din | input | DATA_W | Host data bus |
| wr_stb | output | 1 | One-cycle commit strobe to the command logic |
| wr_addr | output | ADDR_W | Address captured at the start of the cycle |
| wr_data | output | DATA_W | Data captured at the start of the cycle |
| force_read | output | 1 | One-cycle pulse that returns the command logic to read mode |

## Verification
Write cycles are driven in two forms: ones ended by write-enable and ones ended by chip-enable, which shows that either rising strobe commits. Low widths that fall just under and just at the filter threshold separate a rejected glitch from a real cycle. Cycles held with output-enable low, or with the supply flag low, or with the supply falling part way through, separate the three inhibit paths from the normal path. A cycle held through reset checks the arming rule, and moving the buses mid-cycle shows that the values are captured at the start. Random cycles mix all of these factors, and each one is checked against an acceptance function in the bench.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

  // index of each strobe inside the packed pin vectors
  localparam int unsigned PIN_WE = 0;
  localparam int unsigned PIN_OE = 1;
  localparam int unsigned PIN_CE = 2;
  localparam int unsigned N_PINS = 3;

  typedef enum logic [0:0] {
    CYC_IDLE   = 1'b0,
    CYC_ACTIVE = 1'b1
  } cyc_state_e;

  // logical write condition on active-low strobes
  function automatic logic write_allowed(input logic ce_n, input logic oe_n, input logic we_n);
    return (!ce_n) && (!we_n) && oe_n;
  endfunction

  // cycle ends when either enabling strobe goes inactive
  function automatic logic cycle_closing(input logic ce_n, input logic we_n);
    return ce_n || we_n;
  endfunction

  // filter counter: true when the mismatch run has reached the threshold
  function automatic logic run_complete(input int unsigned run, input int unsigned min_w);
    return run >= (min_w - 1);
  endfunction

endpackage

// File: rtl/fwg_sync.sv
module fwg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) chain <= d;
    end else begin : g_multi
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fwg_glitch_filter.sv
module fwg_glitch_filter #(
  parameter int unsigned MIN_W = 3
) (
  input  logic clk,
  input  logic por,
  input  logic d,
  output logic q,
  output logic flip
);
  import fwg_pkg::*;

  localparam int unsigned CW = (MIN_W < 2) ? 1 : $clog2(MIN_W + 1);

  logic [CW-1:0] run_q;
  logic          differs;

  assign differs = (d != q);
  assign flip    = differs && run_complete(int'(run_q), MIN_W);

  always_ff @(posedge clk) begin
    if (por) begin
      // track the pin level during reset so release sees the true state
      q     <= d;
      run_q <= '0;
    end else if (!differs) begin
      run_q <= '0;
    end else if (flip) begin
      q     <= d;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/fwg_arm_ctrl.sv
module fwg_arm_ctrl (
  input  logic clk,
  input  logic por,
  input  logic vcc_q,
  input  logic ce_f,
  input  logic we_f,
  output logic armed,
  output logic force_read,
  output logic supply_drop
);
  logic boot_q;
  logic vcc_d;

  // previous supply sample, kept through reset so a drop at release is seen
  always_ff @(posedge clk) vcc_d <= vcc_q;

  assign supply_drop = vcc_d && !vcc_q;

  always_ff @(posedge clk) begin
    if (por) begin
      armed      <= 1'b0;
      boot_q     <= 1'b1;
      force_read <= 1'b0;
    end else begin
      boot_q     <= 1'b0;
      force_read <= boot_q || supply_drop;
      if (!vcc_q)
        armed <= 1'b0;
      else if (ce_f || we_f)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/fwg_cycle_fsm.sv
module fwg_cycle_fsm #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              por,
  input  logic              armed,
  input  logic              vcc_q,
  input  logic              ce_f,
  input  logic              oe_f,
  input  logic              we_f,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              st_active,
  output logic              start_evt,
  output logic              abort_evt,
  output logic              commit_evt
);
  import fwg_pkg::*;

  cyc_state_e state_q;

  assign st_active  = (state_q == CYC_ACTIVE);
  assign start_evt  = !st_active && armed && vcc_q && write_allowed(ce_f, oe_f, we_f);
  assign abort_evt  = st_active && (!vcc_q || !oe_f);
  assign commit_evt = st_active && !abort_evt && cycle_closing(ce_f, we_f);

  always_ff @(posedge clk) begin
    if (por) begin
      state_q <= CYC_IDLE;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      unique case (state_q)
        CYC_IDLE: begin
          if (start_evt) begin
            state_q <= CYC_ACTIVE;
            wr_addr <= addr;
            wr_data <= din;
          end
        end
        CYC_ACTIVE: begin
          if (abort_evt) begin
            state_q <= CYC_IDLE;
          end else if (commit_evt) begin
            state_q <= CYC_IDLE;
            wr_stb  <= 1'b1;
          end
        end
        default: state_q <= CYC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_write_guard.sv
module flash_write_guard #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned GLITCH_MIN  = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por,
  input  logic              vcc_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              force_read
);
  import fwg_pkg::*;

  logic [N_PINS-1:0] pin_raw;
  logic [N_PINS-1:0] pin_s;
  logic [N_PINS-1:0] pin_f;
  logic [N_PINS-1:0] pin_flip;

  logic vcc_q;
  logic ce_f, oe_f, we_f;
  logic armed;
  logic supply_drop;
  logic st_active, start_evt, abort_evt, commit_evt;

  always_comb begin
    pin_raw         = '1;
    pin_raw[PIN_CE] = ce_n;
    pin_raw[PIN_OE] = oe_n;
    pin_raw[PIN_WE] = we_n;
  end

  generate
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      fwg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pin_raw[i]),
        .q   (pin_s[i])
      );
      fwg_glitch_filter #(.MIN_W(GLITCH_MIN)) u_filt (
        .clk  (clk),
        .por  (por),
        .d    (pin_s[i]),
        .q    (pin_f[i]),
        .flip (pin_flip[i])
      );
    end
  endgenerate

  fwg_sync #(.STAGES(SYNC_STAGES)) u_vcc_sync (
    .clk (clk),
    .d   (vcc_ok),
    .q   (vcc_q)
  );

  assign ce_f = pin_f[PIN_CE];
  assign oe_f = pin_f[PIN_OE];
  assign we_f = pin_f[PIN_WE];

  fwg_arm_ctrl u_arm (
    .clk         (clk),
    .por         (por),
    .vcc_q       (vcc_q),
    .ce_f        (ce_f),
    .we_f        (we_f),
    .armed       (armed),
    .force_read  (force_read),
    .supply_drop (supply_drop)
  );

  fwg_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .por        (por),
    .armed      (armed),
    .vcc_q      (vcc_q),
    .ce_f       (ce_f),
    .oe_f       (oe_f),
    .we_f       (we_f),
    .addr       (addr),
    .din        (din),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .st_active  (st_active),
    .start_evt  (start_evt),
    .abort_evt  (abort_evt),
    .commit_evt (commit_evt)
  );
endmodule

// File: rtl/fwg_checker.sv
module fwg_checker #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              por,
  input logic              vcc_q,
  input logic              oe_f,
  input logic              armed,
  input logic              st_active,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              force_read
);
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (por) wr_stb |=> !wr_stb); // R3
  AST_STB_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (por) wr_stb |-> $past(st_active)); // R2
  AST_STB_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (por) wr_stb |-> $past(vcc_q)); // R6
  AST_DROP_FORCES_READ: assert property (@(posedge clk) disable iff (por) $fell(vcc_q) |=> force_read); // R6
  AST_BOOT_FORCES_READ: assert property (@(posedge clk) disable iff (por) $fell(por) |=> force_read); // R1
  AST_OE_LOW_ABORTS: assert property (@(posedge clk) disable iff (por) (st_active && !oe_f) |=> (!st_active && !wr_stb)); // R4
  AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (por) $rose(st_active) |-> $past(armed)); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (por) (st_active && $past(st_active)) |-> $stable(wr_addr)); // R9
endmodule

bind flash_write_guard fwg_checker #(.ADDR_W(ADDR_W)) u_fwg_checker (
  .clk        (clk),
  .por        (por),
  .vcc_q      (vcc_q),
  .oe_f       (oe_f),
  .armed      (armed),
  .st_active  (st_active),
  .wr_stb     (wr_stb),
  .wr_addr    (wr_addr),
  .force_read (force_read)
);

// File: tb/flash_write_guard_bench.sv
module flash_write_guard_bench;
  localparam int AW   = 16;
  localparam int DW   = 16;
  localparam int GMIN = 3;

  logic          clk = 1'b0;
  logic          por = 1'b1;
  logic          vcc_ok = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          wr_stb, force_read;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int total = 0;
  int bad   = 0;
  int stb_cnt = 0, frc_cnt = 0, dbl_cnt = 0;
  logic [AW-1:0] seen_a;
  logic [DW-1:0] seen_d;
  logic prev_stb = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  flash_write_guard #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_MIN(GMIN)) u_flash_write_guard (
    .clk(clk), .por(por), .vcc_ok(vcc_ok), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .force_read(force_read)
  );

  always @(negedge clk) begin
    if (!por) begin
      if (wr_stb) begin
        stb_cnt++;
        seen_a = wr_addr;
        seen_d = wr_data;
        if (prev_stb) dbl_cnt++;
      end
      if (force_read) frc_cnt++;
    end
    prev_stb = wr_stb;
  end

  // acceptance rule restated from the requirements
  function automatic int expect_commits(bit oe_high, bit supply_on, int low_cycles);
    if (!oe_high || !supply_on) return 0;
    return (low_cycles >= GMIN) ? 1 : 0;
  endfunction

  task automatic check(string req, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // one host cycle; by_ce selects which strobe closes the cycle
  task automatic host_cycle(bit by_ce, int low_cycles, logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; din = d;
    if (by_ce) begin
      we_n = 1'b0; idle(2);
      ce_n = 1'b0; idle(low_cycles);
      ce_n = 1'b1; idle(2);
      we_n = 1'b1;
    end else begin
      ce_n = 1'b0; idle(2);
      we_n = 1'b0; idle(low_cycles);
      we_n = 1'b1; idle(2);
      ce_n = 1'b1;
    end
    idle(12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0, c0, f0;
    s0 = $urandom(32'h5EED_0042);
    idle(10);
    // R1: no strobe during reset, one boot pulse after release
    check("R1 stb in reset", int'(wr_stb), 0);
    por = 1'b0;
    idle(8);
    check("R1 boot force_read pulses", frc_cnt, 1);
    check("R1 no stb after reset", stb_cnt, 0);

    // R2: write-enable closed cycle
    c0 = stb_cnt;
    host_cycle(1'b0, 6, 16'h1234, 16'hA5A5);
    check("R2 commit count", stb_cnt - c0, 1);
    check("R2 addr", int'(seen_a), 32'h1234);
    check("R2 data", int'(seen_d), 32'hA5A5);

    // R10: chip-enable closed cycle
    c0 = stb_cnt;
    host_cycle(1'b1, 6, 16'h0F0F, 16'h3C3C);
    check("R10 commit count", stb_cnt - c0, 1);
    check("R10 data", int'(seen_d), 32'h3C3C);

    // R5: glitch just below threshold, then exactly at threshold
    c0 = stb_cnt;
    host_cycle(1'b0, GMIN - 1, 16'h0001, 16'h0002);
    check("R5 short pulse ignored", stb_cnt - c0, 0);
    c0 = stb_cnt;
    host_cycle(1'b0, GMIN, 16'h0003, 16'h0004);
    check("R5 threshold pulse accepted", stb_cnt - c0, 1);

    // R4: output-enable low inhibits
    c0 = stb_cnt;
    oe_n = 1'b0; idle(6);
    host_cycle(1'b0, 8, 16'h00AA, 16'h00BB);
    oe_n = 1'b1; idle(6);
    check("R4 oe low inhibit", stb_cnt - c0, 0);

    // R6: supply low ignores writes and forces read
    c0 = stb_cnt; f0 = frc_cnt;
    vcc_ok = 1'b0; idle(6);
    check("R6 drop force_read", frc_cnt - f0, 1);
    host_cycle(1'b0, 8, 16'h5555, 16'h6666);
    check("R6 locked out", stb_cnt - c0, 0);
    vcc_ok = 1'b1; idle(6);
    c0 = stb_cnt;
    host_cycle(1'b0, 8, 16'h7777, 16'h8888);
    check("R6 recovered", stb_cnt - c0, 1);

    // R7: supply falls mid-cycle
    c0 = stb_cnt;
    ce_n = 1'b0; idle(2); we_n = 1'b0; idle(8);
    vcc_ok = 1'b0; idle(6);
    we_n = 1'b1; idle(2); ce_n = 1'b1; idle(10);
    check("R7 mid-cycle drop", stb_cnt - c0, 0);
    vcc_ok = 1'b1; idle(6);

    // R9: bus moves after start
    c0 = stb_cnt;
    addr = 16'hBEEF; din = 16'hCAFE;
    ce_n = 1'b0; idle(2); we_n = 1'b0; idle(GMIN + 6);
    addr = 16'h0000; din = 16'hFFFF; idle(3);
    we_n = 1'b1; idle(2); ce_n = 1'b1; idle(12);
    check("R9 count", stb_cnt - c0, 1);
    check("R9 addr held", int'(seen_a), 32'hBEEF);
    check("R9 data held", int'(seen_d), 32'hCAFE);

    // R8: strobes low through reset
    ce_n = 1'b0; we_n = 1'b0;
    por = 1'b1; idle(8);
    por = 1'b0; idle(10);
    c0 = stb_cnt;
    we_n = 1'b1; idle(2); ce_n = 1'b1; idle(12);
    check("R8 power-up inhibit", stb_cnt - c0, 0);
    c0 = stb_cnt;
    host_cycle(1'b0, 8, 16'h4242, 16'h2424);
    check("R8 next cycle accepted", stb_cnt - c0, 1);

    // random mix of closing strobe, width, inhibit and supply
    for (int i = 0; i < 60; i++) begin
      bit by_ce, oe_hi, sup;
      int w;
      logic [AW-1:0] ra;
      logic [DW-1:0] rd;
      by_ce = 1'($urandom_range(0, 1));
      oe_hi = ($urandom_range(0, 3) != 0);
      sup   = ($urandom_range(0, 4) != 0);
      w     = int'($urandom_range(1, 7));
      ra    = AW'($urandom);
      rd    = DW'($urandom);
      if (!oe_hi) begin oe_n = 1'b0; idle(6); end
      if (!sup)   begin vcc_ok = 1'b0; idle(6); end
      c0 = stb_cnt;
      host_cycle(by_ce, w, ra, rd);
      check("R2/R4/R5/R6 random count", stb_cnt - c0, expect_commits(oe_hi, sup, w));
      if (expect_commits(oe_hi, sup, w) == 1) begin
        check("R2 random addr", int'(seen_a), int'(ra));
        check("R2 random data", int'(seen_d), int'(rd));
      end
      oe_n = 1'b1; vcc_ok = 1'b1; idle(6);
    end

    // R3: strobe never two cycles long
    check("R3 single-cycle strobe", dbl_cnt, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule